// File: doc/BRIEF.md
# Clock Sync Supervisor State Machine

This block is the decision layer of a slave clock discipline loop. It follows the discipline through five phases: acquiring the master, arming the next one-second output pulse, tracking, holding over while the master is silent, and slewing back after a large drift. It takes strobes and flags from the timestamp path and drives three control lines to the loop filter and pulse generator. It does no filter arithmetic and no DAC traffic.

Software first calibrates the local counter against the master and raises the calibration flag. The supervisor then asks the pulse generator to load the compare value for the next second boundary, once per pulse period. If sync packets stop arriving for longer than a programmable number of cycles, it freezes the DAC. When packets return, it picks a recovery path from the drift measured against programmable thresholds and from whether the absolute reference was lost while it was holding over.

Top module: `clkdisc_supervisor`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the acquire state, with all three control outputs low. State codes on `state_o`: 0 acquire, 1 arm, 2 track, 3 hold, 4 slew.
- R2: In acquire the machine moves to arm on the edge where `cal_done_i` is high. Sync, period tick and reference-lost inputs have no effect in acquire.
- R3: The arm state lasts exactly one cycle. `cmp_load_o` is high during that cycle, and the next state is track.
- R4: In track, a `period_tick_i` strobe sends the machine back to arm.
- R5: A silence counter is cleared by `sync_evt_i`, counts sync-free cycles spent in arm or track, and is cleared in every other state. In track, a sync-free cycle whose counter value is at least `timeout_i` moves the machine to hold. With limit L, hold follows the (L+1)-th sync-free cycle after the last sync. This timeout takes priority over a period tick in the same cycle.
- R6: In hold, `dac_hold_o` is high, and the machine stays in hold until a sync event arrives.
- R7: If `ref_lost_i` was high in any hold cycle, including the cycle of the returning sync event, that sync event sends the machine to acquire.
- R8: If no reference was lost, a sync event in hold goes to slew when `drift_i` is strictly greater than `resync_thr_i`, and to track otherwise.
- R9: In slew, `slow_corr_o` is high. A sync event with `drift_i` less than or equal to `window_thr_i` returns the machine to track. Any other cycle leaves it in slew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_evt_i | input | 1 | Strobe: a timestamped sync packet was seen |
| cal_done_i | input | 1 | Local counter is calibrated to the master |
| period_tick_i | input | 1 | Strobe: the current second pulse has been emitted |
| ref_lost_i | input | 1 | Absolute time reference lost |
| drift_i | input | DRIFT_W | Measured drift magnitude, valid with sync_evt_i |
| resync_thr_i | input | DRIFT_W | Drift above this value on return from hold forces slew |
| window_thr_i | input | DRIFT_W | Drift at or below this value ends slew |
| timeout_i | input | TMO_W | Sync-free cycles tolerated in track |
| dac_hold_o | output | 1 | Freeze the DAC output |
| cmp_load_o | output | 1 | Load the next one-second compare value |
| slow_corr_o | output | 1 | Loop filter in slow correction mode |
| state_o | output | 3 | Current state code |

## Verification
Every output comes straight from the state register, so a wrong transition shows on `state_o` and the control lines one cycle after the input edge that caused it. A wrong silence count shows up differently: the entry into hold moves by one or more cycles. A latch for the lost reference that is stale or missing only shows when the next sync arrives in hold, as the wrong choice between acquire and track or slew. The bench therefore compares all four outputs with a behavioural model on every cycle. It also pins down the exact timeout cycle, the threshold equality cases and the same-cycle priorities.

// File: rtl/clkdisc_pkg.sv
package clkdisc_pkg;

  typedef enum logic [2:0] {
    SUP_ACQUIRE = 3'd0,
    SUP_ARM     = 3'd1,
    SUP_TRACK   = 3'd2,
    SUP_HOLD    = 3'd3,
    SUP_SLEW    = 3'd4
  } sup_state_e;

  // Drift strictly beyond a limit (used for the resync decision).
  function automatic logic over_limit(input logic [31:0] mag, input logic [31:0] lim);
    return mag > lim;
  endfunction

  // Drift at or inside a window (used to end slow correction).
  function automatic logic inside_window(input logic [31:0] mag, input logic [31:0] win);
    return mag <= win;
  endfunction

endpackage

// File: rtl/clkdisc_silence_timer.sv
module clkdisc_silence_timer #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             judge_i,
  input  logic             sync_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || sync_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = judge_i && !sync_i && (cnt_q >= limit_i);
endmodule

// File: rtl/clkdisc_ref_latch.sv
module clkdisc_ref_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic set_i,
  output logic seen_o
);
  logic lat_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      lat_q <= 1'b0;
    end else if (set_i) begin
      lat_q <= 1'b1;
    end
  end

  assign seen_o = lat_q || (arm_i && set_i);
endmodule

// File: rtl/clkdisc_fsm.sv
module clkdisc_fsm
  import clkdisc_pkg::*;
#(
  parameter int DRIFT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cal_done_i,
  input  logic               sync_i,
  input  logic               period_tick_i,
  input  logic               expire_i,
  input  logic               lost_seen_i,
  input  logic [DRIFT_W-1:0] drift_i,
  input  logic [DRIFT_W-1:0] resync_thr_i,
  input  logic [DRIFT_W-1:0] window_thr_i,
  output sup_state_e         state_o
);
  sup_state_e state_q, state_d;
  logic       drift_big, drift_ok;

  assign drift_big = over_limit(32'(drift_i), 32'(resync_thr_i));
  assign drift_ok  = inside_window(32'(drift_i), 32'(window_thr_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUP_ACQUIRE: if (cal_done_i) state_d = SUP_ARM;
      SUP_ARM:     state_d = SUP_TRACK;
      SUP_TRACK: begin
        if (expire_i)           state_d = SUP_HOLD;
        else if (period_tick_i) state_d = SUP_ARM;
      end
      SUP_HOLD: begin
        if (sync_i) begin
          if (lost_seen_i)    state_d = SUP_ACQUIRE;
          else if (drift_big) state_d = SUP_SLEW;
          else                state_d = SUP_TRACK;
        end
      end
      SUP_SLEW: if (sync_i && drift_ok) state_d = SUP_TRACK;
      default:  state_d = SUP_ACQUIRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SUP_ACQUIRE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/clkdisc_supervisor.sv
module clkdisc_supervisor
  import clkdisc_pkg::*;
#(
  parameter int DRIFT_W = 16,
  parameter int TMO_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_evt_i,
  input  logic               cal_done_i,
  input  logic               period_tick_i,
  input  logic               ref_lost_i,
  input  logic [DRIFT_W-1:0] drift_i,
  input  logic [DRIFT_W-1:0] resync_thr_i,
  input  logic [DRIFT_W-1:0] window_thr_i,
  input  logic [TMO_W-1:0]   timeout_i,
  output logic               dac_hold_o,
  output logic               cmp_load_o,
  output logic               slow_corr_o,
  output logic [2:0]         state_o
);
  sup_state_e cur_state;
  logic       in_arm, in_track, in_hold, in_slew;
  logic       silence_expire;
  logic       lost_seen;

  assign in_arm   = (cur_state == SUP_ARM);
  assign in_track = (cur_state == SUP_TRACK);
  assign in_hold  = (cur_state == SUP_HOLD);
  assign in_slew  = (cur_state == SUP_SLEW);

  clkdisc_silence_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (in_arm || in_track),
    .judge_i  (in_track),
    .sync_i   (sync_evt_i),
    .limit_i  (timeout_i),
    .expire_o (silence_expire)
  );

  clkdisc_ref_latch u_lost (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (in_hold),
    .set_i  (ref_lost_i),
    .seen_o (lost_seen)
  );

  clkdisc_fsm #(.DRIFT_W(DRIFT_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cal_done_i    (cal_done_i),
    .sync_i        (sync_evt_i),
    .period_tick_i (period_tick_i),
    .expire_i      (silence_expire),
    .lost_seen_i   (lost_seen),
    .drift_i       (drift_i),
    .resync_thr_i  (resync_thr_i),
    .window_thr_i  (window_thr_i),
    .state_o       (cur_state)
  );

  assign dac_hold_o  = in_hold;
  assign cmp_load_o  = in_arm;
  assign slow_corr_o = in_slew;
  assign state_o     = cur_state;
endmodule

// File: rtl/clkdisc_supervisor_chk.sv
module clkdisc_supervisor_chk #(
  parameter int DRIFT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         state_o,
  input logic               sync_evt_i,
  input logic               cal_done_i,
  input logic [DRIFT_W-1:0] drift_i,
  input logic [DRIFT_W-1:0] resync_thr_i,
  input logic [DRIFT_W-1:0] window_thr_i,
  input logic               cmp_load_o,
  input logic               dac_hold_o,
  input logic               slow_corr_o,
  input logic               lost_seen,
  input logic               silence_expire
);
  import clkdisc_pkg::*;

  p_reset_acquire_r1: assert property (@(posedge clk)
    rst |=> (state_o == SUP_ACQUIRE) && !cmp_load_o && !dac_hold_o && !slow_corr_o);

  p_cal_to_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == SUP_ACQUIRE && cal_done_i) |=> cmp_load_o);

  p_arm_single_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_load_o |=> !cmp_load_o && (state_o == SUP_TRACK));

  p_timeout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    silence_expire |=> dac_hold_o);

  p_hold_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (dac_hold_o && !sync_evt_i) |=> dac_hold_o);

  p_lost_reacquire_r7: assert property (@(posedge clk) disable iff (rst)
    (dac_hold_o && sync_evt_i && lost_seen) |=> (state_o == SUP_ACQUIRE));

  p_big_drift_slew_r8: assert property (@(posedge clk) disable iff (rst)
    (dac_hold_o && sync_evt_i && !lost_seen && drift_i > resync_thr_i) |=> slow_corr_o);

  p_slew_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (slow_corr_o && sync_evt_i && drift_i <= window_thr_i) |=> (state_o == SUP_TRACK));

  p_outputs_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmp_load_o, dac_hold_o, slow_corr_o}));
endmodule

bind clkdisc_supervisor clkdisc_supervisor_chk #(.DRIFT_W(DRIFT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .state_o        (state_o),
  .sync_evt_i     (sync_evt_i),
  .cal_done_i     (cal_done_i),
  .drift_i        (drift_i),
  .resync_thr_i   (resync_thr_i),
  .window_thr_i   (window_thr_i),
  .cmp_load_o     (cmp_load_o),
  .dac_hold_o     (dac_hold_o),
  .slow_corr_o    (slow_corr_o),
  .lost_seen      (lost_seen),
  .silence_expire (silence_expire)
);

// File: tb/clkdisc_supervisor_bench.sv
module clkdisc_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TW = 12;
  localparam int QMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_evt = 0, cal_done = 0, period_tick = 0, ref_lost = 0;
  logic [DW-1:0] drift = '0;
  logic [DW-1:0] resync_thr = 16'd100;
  logic [DW-1:0] window_thr = 16'd40;
  logic [TW-1:0] tmo = 12'd5;
  logic dac_hold, cmp_load, slow_corr;
  logic [2:0] state;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdisc_supervisor #(.DRIFT_W(DW), .TMO_W(TW)) u_clkdisc_supervisor (
    .clk(clk), .rst(rst), .sync_evt_i(sync_evt), .cal_done_i(cal_done),
    .period_tick_i(period_tick), .ref_lost_i(ref_lost), .drift_i(drift),
    .resync_thr_i(resync_thr), .window_thr_i(window_thr), .timeout_i(tmo),
    .dac_hold_o(dac_hold), .cmp_load_o(cmp_load), .slow_corr_o(slow_corr),
    .state_o(state)
  );

  // Behavioural reference: state number, silent-cycle count, lost flag.
  int m_st = 0, m_q = 0;
  bit m_lost = 0, m_started = 0;

  always @(posedge clk) begin
    int nst;
    if (rst) begin
      m_st = 0; m_q = 0; m_lost = 0;
    end else begin
      nst = m_st;
      if (m_st == 0 && cal_done) nst = 1;
      else if (m_st == 1) nst = 2;
      else if (m_st == 2) begin
        if (!sync_evt && m_q >= int'(tmo)) nst = 3;
        else if (period_tick) nst = 1;
      end else if (m_st == 3 && sync_evt) begin
        if (m_lost || ref_lost) nst = 0;
        else if (int'(drift) > int'(resync_thr)) nst = 4;
        else nst = 2;
      end else if (m_st == 4 && sync_evt && int'(drift) <= int'(window_thr)) nst = 2;
      if (m_st == 1 || m_st == 2) m_q = sync_evt ? 0 : (m_q < QMAX ? m_q + 1 : m_q);
      else m_q = 0;
      m_lost = (m_st == 3) ? (m_lost || ref_lost) : 1'b0;
      m_st = nst;
    end
    m_started = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_started && !finished) begin
      check(int'(state) == m_st, "R1 state model", int'(state), m_st);
      check(cmp_load == (m_st == 1), "R3 cmp_load model", int'(cmp_load), int'(m_st == 1));
      check(dac_hold == (m_st == 3), "R6 dac_hold model", int'(dac_hold), int'(m_st == 3));
      check(slow_corr == (m_st == 4), "R9 slow_corr model", int'(slow_corr), int'(m_st == 4));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_state(input int exp, input string req);
    check(int'(state) == exp, req, int'(state), exp);
  endtask

  task automatic sync_once(input int d);
    sync_evt = 1; drift = DW'(d);
    tick();
    sync_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic reach_hold();
    for (int i = 0; i < 20 && state != 3'd3; i++) tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    idle(3);
    rst = 0;
    // R1: reset state
    expect_state(0, "R1 reset state");
    check(!cmp_load && !dac_hold && !slow_corr, "R1 outputs low", int'({cmp_load, dac_hold, slow_corr}), 0);
    // R2: other inputs ignored in acquire
    sync_evt = 1; period_tick = 1; ref_lost = 1; tick();
    sync_evt = 0; period_tick = 0; ref_lost = 0;
    expect_state(0, "R2 acquire ignores strobes");
    cal_done = 1; tick(); cal_done = 0;
    expect_state(1, "R2 cal to arm");
    check(cmp_load, "R3 load in arm", int'(cmp_load), 1);
    tick();
    expect_state(2, "R3 arm lasts one cycle");
    // R4: period tick re-arms
    period_tick = 1; tick(); period_tick = 0;
    expect_state(1, "R4 tick to arm");
    tick();
    // R5: exact timeout cycle
    sync_once(0);
    idle(5);
    expect_state(2, "R5 still tracking after L silent cycles");
    tick();
    expect_state(3, "R5 hold after L+1 silent cycles");
    // R6: hold persists without sync
    period_tick = 1; idle(3); period_tick = 0;
    expect_state(3, "R6 hold waits for sync");
    check(dac_hold, "R6 dac hold", int'(dac_hold), 1);
    // R8 boundary: equal to threshold -> track
    sync_once(100);
    expect_state(2, "R8 drift equal threshold to track");
    idle(6);
    expect_state(3, "R5 hold again");
    sync_once(101);
    expect_state(4, "R8 big drift to slew");
    sync_once(41);
    expect_state(4, "R9 outside window stays");
    idle(2);
    expect_state(4, "R9 slew without sync stays");
    sync_once(40);
    expect_state(2, "R9 window edge to track");
    // R7: lost reference earlier in hold
    reach_hold();
    expect_state(3, "R5 reached hold");
    ref_lost = 1; tick(); ref_lost = 0;
    idle(2);
    expect_state(3, "R7 loss alone keeps hold");
    sync_once(0);
    expect_state(0, "R7 loss then sync reacquires");
    // R7: loss in the same cycle as sync
    cal_done = 1; tick(); cal_done = 0;
    tick();
    reach_hold();
    sync_evt = 1; ref_lost = 1; drift = '0; tick();
    sync_evt = 0; ref_lost = 0;
    expect_state(0, "R7 same-cycle loss reacquires");
    // R5: timeout beats period tick
    cal_done = 1; tick(); cal_done = 0;
    tick();
    sync_once(0);
    idle(5);
    period_tick = 1; tick(); period_tick = 0;
    expect_state(3, "R5 timeout over period tick");
    // Mixed traffic against the model
    tmo = 12'd7;
    for (int i = 0; i < 3000; i++) begin
      sync_evt    = ($urandom_range(5) == 0);
      cal_done    = ($urandom_range(19) == 0);
      period_tick = ($urandom_range(14) == 0);
      ref_lost    = ($urandom_range(39) == 0);
      drift       = DW'($urandom_range(160));
      rst         = ($urandom_range(499) == 0);
      tick();
    end
    rst = 0; sync_evt = 0; cal_done = 0; period_tick = 0; ref_lost = 0;
    tick();
    summary();
  end
endmodule